// File: doc/BRIEF.md
# Memory ECC Error Logger

This block keeps a record of the first ECC failure seen on memory reads. For every read, the ECC checker raises one of two strobes: one for an error it corrected in a single bit, or one for an error in two bits that it could not correct. With the strobe it presents a syndrome and the address of the read. The logger captures the address into a 32-bit register. It packs the error class, a sticky multiple-error flag and the syndrome into a 12-bit status register.

When a later error arrives while one is already logged, the first record is kept and only the multiple-error flag is raised. Software reads both registers through an indexed I/O read port. A debug port sees the same values through a direct parallel tap. An I/O write to the clear index empties both registers.

Top module: `ecc_err_log`

## Requirements
- R1: After reset the address register and the status register both read as zero.
- R2: A single-bit report arriving when no error is logged sets status bit 1 one cycle later. It stores the syndrome in status bits 11:5 and the read address in the address register. Status bits 0, 2, 3 and 4 stay zero.
- R3: A double-bit report arriving when no error is logged sets status bit 3 one cycle later. It stores the syndrome in bits 11:5 and captures the address. The syndrome carries the XOR of the two failing bit indices.
- R4: If a single-bit and a double-bit report arrive in the same cycle, the double-bit report is logged: bit 3 is set and bit 1 is clear.
- R5: An error arriving while an earlier one is logged sets status bit 0. It leaves the address, the class bits and the syndrome unchanged.
- R6: Status bit 0 and the rest of the record stay unchanged across idle cycles until a clear.
- R7: An I/O write to index 3 clears both registers one cycle later. A write to any other index has no effect on either register.
- R8: If a clear and an error report arrive in the same cycle, the report is logged as a fresh first error, with bit 0 clear.
- R9: The I/O read port returns data in the same cycle as the index. Index 0 returns the address register. Index 1 returns the status register in bits 11:0, with the upper bits zero. Every other index returns zero.
- R10: The debug address and debug status outputs always equal the two registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sbe_i | input | 1 | Corrected single-bit error strobe |
| dbe_i | input | 1 | Uncorrectable double-bit error strobe |
| syn_i | input | 7 | Syndrome of the failing read |
| addr_i | input | 32 | Address of the failing read |
| io_wr_i | input | 1 | I/O write strobe |
| io_wr_idx_i | input | 4 | I/O write register index |
| io_rd_idx_i | input | 4 | I/O read register index |
| io_rd_data_o | output | 32 | I/O read data |
| dbg_addr_o | output | 32 | Debug tap of the address register |
| dbg_stat_o | output | 12 | Debug tap of the status register |

## Verification
The assertions assume the ECC checker presents a syndrome and an address only in a cycle where it raises a strobe. They also assume the strobes are always driven to known levels, never left unknown. The stimulus keeps both inputs at zero whenever no strobe is high.

The stimulus changes inputs only between clock edges. It reads and clears the registers only through the I/O ports, so every assertion sees a legal history. Simultaneous-strobe cases are included on purpose, because the priority rules must cover them.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
    localparam int ADDR_W   = 32;
    localparam int STAT_W   = 12;
    localparam int SYN_LSB  = 5;
    localparam int SYN_W    = STAT_W - SYN_LSB;
    localparam int IDX_W    = 4;
    localparam int DATA_W   = 32;

    localparam int MULTI_BIT = 0;
    localparam int SBE_BIT   = 1;
    localparam int DBE_BIT   = 3;

    localparam logic [IDX_W-1:0] RD_ADDR_IDX = 4'd0;
    localparam logic [IDX_W-1:0] RD_STAT_IDX = 4'd1;
    localparam logic [IDX_W-1:0] WR_CLR_IDX  = 4'd3;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [STAT_W-1:0] stat;
    } err_rec_t;
endpackage

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
    import ecc_log_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sbe_i,
    input  logic              dbe_i,
    input  logic [SYN_W-1:0]  syn_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              clr_i,
    output err_rec_t          rec_o
);
    err_rec_t rec_d, rec_q;
    logic     logged;
    logic     hit;

    always_comb begin
        rec_d  = rec_q;
        logged = rec_q.stat[SBE_BIT] | rec_q.stat[DBE_BIT];
        hit    = sbe_i | dbe_i;
        if (clr_i) begin
            rec_d  = '0;
            logged = 1'b0;
        end
        if (hit) begin
            if (logged) begin
                rec_d.stat[MULTI_BIT] = 1'b1;
            end else begin
                rec_d.addr = addr_i;
                rec_d.stat = '0;
                rec_d.stat[STAT_W-1:SYN_LSB] = syn_i;
                if (dbe_i) rec_d.stat[DBE_BIT] = 1'b1;
                else       rec_d.stat[SBE_BIT] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign rec_o = rec_q;

    // R6: multi flag sticky until a clear
    p_multi_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_q.stat[MULTI_BIT] && !clr_i) |=> rec_q.stat[MULTI_BIT]);

    // R5: a logged record keeps its address and syndrome
    p_record_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((rec_q.stat[SBE_BIT] || rec_q.stat[DBE_BIT]) && !clr_i)
        |=> ($stable(rec_q.addr) && $stable(rec_q.stat[STAT_W-1:SYN_LSB])));

    // R4: double-bit wins over single-bit on a fresh log
    p_dbe_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sbe_i && dbe_i && (clr_i || !(rec_q.stat[SBE_BIT] || rec_q.stat[DBE_BIT])))
        |=> (rec_q.stat[DBE_BIT] && !rec_q.stat[SBE_BIT]));

    // R7: a clear with no report empties the record
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !sbe_i && !dbe_i) |=> (rec_q == '0));

    // R2: at most one error class is ever recorded
    p_one_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rec_q.stat[SBE_BIT], rec_q.stat[DBE_BIT]}));

    // R8: a report during a clear starts a fresh record
    p_clear_and_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (sbe_i || dbe_i)) |=> !rec_q.stat[MULTI_BIT]);
endmodule

// File: rtl/ecc_io_rdmux.sv
module ecc_io_rdmux
    import ecc_log_pkg::*;
(
    input  logic [IDX_W-1:0]  idx_i,
    input  err_rec_t          rec_i,
    output logic [DATA_W-1:0] data_o
);
    always_comb begin
        data_o = '0;
        case (idx_i)
            RD_ADDR_IDX: data_o[ADDR_W-1:0] = rec_i.addr;
            RD_STAT_IDX: data_o[STAT_W-1:0] = rec_i.stat;
            default:     data_o = '0;
        endcase
    end

    // R9: upper bits of a status read are zero
    always_comb begin
        if (idx_i == RD_STAT_IDX)
            a_stat_zext_r9: assert (data_o[DATA_W-1:STAT_W] == '0);
    end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import ecc_log_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sbe_i,
    input  logic              dbe_i,
    input  logic [SYN_W-1:0]  syn_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              io_wr_i,
    input  logic [IDX_W-1:0]  io_wr_idx_i,
    input  logic [IDX_W-1:0]  io_rd_idx_i,
    output logic [DATA_W-1:0] io_rd_data_o,
    output logic [ADDR_W-1:0] dbg_addr_o,
    output logic [STAT_W-1:0] dbg_stat_o
);
    err_rec_t rec;
    logic     clr;

    assign clr = io_wr_i && (io_wr_idx_i == WR_CLR_IDX);

    ecc_err_capture u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .sbe_i  (sbe_i),
        .dbe_i  (dbe_i),
        .syn_i  (syn_i),
        .addr_i (addr_i),
        .clr_i  (clr),
        .rec_o  (rec)
    );

    ecc_io_rdmux u_rd (
        .idx_i  (io_rd_idx_i),
        .rec_i  (rec),
        .data_o (io_rd_data_o)
    );

    assign dbg_addr_o = rec.addr;
    assign dbg_stat_o = rec.stat;

    // R7: a write to another index leaves the status unchanged when idle
    p_other_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr_i && io_wr_idx_i != WR_CLR_IDX && !sbe_i && !dbe_i)
        |=> $stable(dbg_stat_o));
endmodule

// File: tb/tb_ecc_err_log.sv
module tb_ecc_err_log;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sbe_i, dbe_i;
    logic [6:0]  syn_i;
    logic [31:0] addr_i;
    logic        io_wr_i;
    logic [3:0]  io_wr_idx_i, io_rd_idx_i;
    logic [31:0] io_rd_data_o, dbg_addr_o;
    logic [11:0] dbg_stat_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    ecc_err_log dut (.*);

    typedef struct packed {
        logic        sbe;
        logic        dbe;
        logic [6:0]  syn;
        logic [31:0] addr;
        logic        clr;
        logic [11:0] exp_stat;
        logic [31:0] exp_addr;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 7'd62,  32'h0F0, 1'b0, 12'h7C2, 32'h0F0}, // R2
        '{1'b1, 1'b0, 7'd5,   32'h100, 1'b0, 12'h7C3, 32'h0F0}, // R5
        '{1'b0, 1'b0, 7'd0,   32'h0,   1'b1, 12'h000, 32'h000}, // R7
        '{1'b0, 1'b1, 7'd124, 32'h0F0, 1'b0, 12'hF88, 32'h0F0}, // R3
        '{1'b0, 1'b1, 7'd1,   32'h200, 1'b0, 12'hF89, 32'h0F0}, // R5
        '{1'b0, 1'b0, 7'd0,   32'h0,   1'b0, 12'hF89, 32'h0F0}, // R6
        '{1'b1, 1'b0, 7'd3,   32'h044, 1'b1, 12'h062, 32'h044}, // R8
        '{1'b0, 1'b0, 7'd0,   32'h0,   1'b1, 12'h000, 32'h000}, // R7
        '{1'b1, 1'b1, 7'd9,   32'hABC, 1'b0, 12'h128, 32'hABC}, // R4
        '{1'b0, 1'b0, 7'd0,   32'h0,   1'b1, 12'h000, 32'h000}  // R7
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic idle_in();
        sbe_i = 0; dbe_i = 0; syn_i = '0; addr_i = '0;
        io_wr_i = 0; io_wr_idx_i = '0;
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle_in();
        io_rd_idx_i = 4'd1;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 stat", {20'd0, dbg_stat_o}, 32'd0);
        chk("R1 addr", dbg_addr_o, 32'd0);

        for (int i = 0; i < NV; i++) begin
            sbe_i = VEC[i].sbe; dbe_i = VEC[i].dbe;
            syn_i = VEC[i].syn; addr_i = VEC[i].addr;
            io_wr_i = VEC[i].clr; io_wr_idx_i = 4'd3;
            @(negedge clk);
            idle_in();
            chk($sformatf("R2-table %0d stat", i), {20'd0, dbg_stat_o}, {20'd0, VEC[i].exp_stat});
            chk($sformatf("R3-table %0d addr", i), dbg_addr_o, VEC[i].exp_addr);
        end

        // R5 R6: log, second error, idle many cycles
        sbe_i = 1; syn_i = 7'd17; addr_i = 32'hDEAD_BEE0;
        @(negedge clk);
        dbe_i = 1; sbe_i = 0; syn_i = 7'd2; addr_i = 32'h1234;
        @(negedge clk);
        idle_in();
        repeat (20) @(negedge clk);
        chk("R6 sticky stat", {20'd0, dbg_stat_o}, {20'd0, 12'h223});
        chk("R5 addr kept", dbg_addr_o, 32'hDEAD_BEE0);

        // R7: write to other index, no effect
        io_wr_i = 1; io_wr_idx_i = 4'd2;
        @(negedge clk);
        idle_in();
        chk("R7 other idx stat", {20'd0, dbg_stat_o}, {20'd0, 12'h223});
        chk("R7 other idx addr", dbg_addr_o, 32'hDEAD_BEE0);

        // R9 R10: read port
        io_rd_idx_i = 4'd0; #1;
        chk("R9 rd addr", io_rd_data_o, 32'hDEAD_BEE0);
        io_rd_idx_i = 4'd1; #1;
        chk("R9 rd stat", io_rd_data_o, 32'h0000_0223);
        io_rd_idx_i = 4'd5; #1;
        chk("R9 rd other", io_rd_data_o, 32'd0);
        chk("R10 dbg stat", {20'd0, dbg_stat_o}, 32'h223);

        // R7: clear then read back
        io_wr_i = 1; io_wr_idx_i = 4'd3;
        @(negedge clk);
        idle_in();
        io_rd_idx_i = 4'd0; #1;
        chk("R7 rd addr cleared", io_rd_data_o, 32'd0);
        io_rd_idx_i = 4'd1; #1;
        chk("R7 rd stat cleared", io_rd_data_o, 32'd0);

        // R1: reset while logged
        sbe_i = 1; syn_i = 7'd1; addr_i = 32'h55;
        @(negedge clk);
        idle_in();
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        chk("R1 reset clears stat", {20'd0, dbg_stat_o}, 32'd0);
        chk("R1 reset clears addr", dbg_addr_o, 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule